// File: doc/BRIEF.md
# Serial Word EEPROM Model

This block is a synthesizable stand-in for a small serial EEPROM organised as 16-bit words. A host talks to it over four wires: chip select, serial clock, serial data in and serial data out. All four are sampled on the system clock, and the block acts on each rising edge of the serial clock while chip select is high. A transaction is a 1 start bit, a 2-bit opcode and an address of `ADDR_W` bits (6 or 8). The host then either sends 16 data bits or receives 17 bits: a dummy 0 followed by the word. Every field goes most significant bit first.

Programming commands only take effect after a write-enable command. They commit when chip select falls. A busy timer of `BUSY_CYCLES` system clocks stands in for the write time. When chip select is raised again after a commit, data out holds 0 while the timer runs and goes to 1 once it expires.

The control FSM has six states:
- `ST_IDLE` waits for a start bit.
- `ST_OPC` takes two opcode bits and moves to `ST_ADDR`.
- `ST_ADDR` takes the address. On its last bit it goes to `ST_RD` for a read, to `ST_DATA` for write or write-all, and to `ST_HOLD` for everything else.
- `ST_DATA` takes 16 data bits and then goes to `ST_HOLD`.
- `ST_RD` shifts the word out.
- `ST_HOLD` ignores further clocks.

Chip select low sends every state back to `ST_IDLE`.

Top module: `eep_serial`

## Requirements
- R1: After reset, write enable is cleared, every word reads 0xFFFF and dout is 0.
- R2: In idle, serial clock edges with din at 0 are ignored; the first edge with din at 1 and chip select high is the start bit.
- R3: Opcode 10 is a read. On the edge that clocks in the last address bit, dout shows a dummy 0. Each of the following 16 rising edges presents the next word bit, MSB first.
- R4: Opcode 01 is a write. It is followed by 16 data bits, MSB first, which are stored at the address when writes are enabled.
- R5: Opcode 11 erases one word to 0xFFFF when writes are enabled.
- R6: Opcode 00 selects an extended command from the top two address bits; the remaining address bits are ignored. Code 11 enables writes and code 00 disables them.
- R7: Extended code 10 sets every word to 0xFFFF when writes are enabled.
- R8: Extended code 01 is followed by 16 data bits, which are written to every word when writes are enabled.
- R9: With writes disabled, write, erase, erase-all and write-all leave memory unchanged and start no busy period.
- R10: Chip select low returns the FSM to idle. A command that has not received all of its bits has no effect. A complete programming command commits when chip select falls.
- R11: After a commit, dout is 0 while chip select is high and the busy timer runs, and 1 after it expires. Start bits are ignored while busy.
- R12: `ADDR_W` sets the address field width. With 8 bits, addresses above 63 are distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; its rising edges shift bits |
| din | input | 1 | Serial command, address and data in |
| dout | output | 1 | Serial read data and ready status |

## Verification
The bench builds two copies with `BUSY_CYCLES` = 20, one with `ADDR_W` = 6 and one with `ADDR_W` = 8. The short busy window lets the bench see both the low and the high half of the ready status within one chip-select period. The narrow copy covers every command and the write-protection cases against a reference model of the whole 64-word array. The wide copy shows that an 8-bit extended-command field decodes and that address 200 does not alias onto address 8 or 72.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_RD, ST_HOLD
    } eep_state_e;

    typedef enum logic [2:0] {
        PG_NONE, PG_WRITE, PG_ERASE, PG_WRAL, PG_ERAL
    } eep_prog_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] XC_LOCK   = 2'b00;
    localparam logic [1:0] XC_FILL   = 2'b01;
    localparam logic [1:0] XC_CLEAR  = 2'b10;
    localparam logic [1:0] XC_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_sck_edge.sv
module eep_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1) < 1 ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left <= '0;
        else if (start)      left <= CW'(CYCLES);
        else if (left != '0) left <= left - 1'b1;
    end

    assign busy = (left != '0);

    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && CYCLES > 0) |=> busy); // R11
endmodule

// File: rtl/eep_word_array.sv
module eep_word_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  eep_prog_e         op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];
    logic              bulk;
    logic              single;
    logic [WORD_W-1:0] value;

    assign bulk   = (op == PG_WRAL) || (op == PG_ERAL);
    assign single = (op == PG_WRITE) || (op == PG_ERASE);
    assign value  = ((op == PG_WRITE) || (op == PG_WRAL)) ? wr_data : '1;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '1;
            else if (go && (bulk || (single && wr_addr == ADDR_W'(g))))
                words[g] <= value;
        end
    end

    assign rd_word = words[rd_addr];

    AST_CLEAR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == PG_ERAL) |=> (words[0] == '1 && words[DEPTH-1] == '1)); // R7
endmodule

// File: rtl/eep_serial.sv
module eep_serial
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic din,
    output logic dout
);
    localparam int LONGEST = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    eep_state_e        state, nxt;
    eep_prog_e         pend;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        op_sr;
    logic [ADDR_W-1:0] addr_sr, addr_full;
    logic [WORD_W-1:0] data_sr, rd_word;
    logic [WORD_W:0]   rd_sr;
    logic              wen, stat_mode, rise, busy, commit;
    logic              addr_last, data_last;
    logic [1:0]        ext_code;

    eep_sck_edge u_edge (.clk(clk), .rst_n(rst_n), .sck(sck), .rise(rise));

    eep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy));

    eep_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .go(commit), .op(pend),
        .wr_addr(addr_sr), .wr_data(data_sr),
        .rd_addr(addr_full), .rd_word(rd_word));

    assign addr_full = {addr_sr[ADDR_W-2:0], din};
    assign ext_code  = addr_full[ADDR_W-1 -: 2];
    assign addr_last = (state == ST_ADDR) && (cnt == CNT_W'(ADDR_W - 1));
    assign data_last = (state == ST_DATA) && (cnt == CNT_W'(WORD_W - 1));
    assign commit    = !cs && (pend != PG_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!cs) begin
            nxt = ST_IDLE;
        end else if (rise) begin
            unique case (state)
                ST_IDLE: if (din && !busy) nxt = ST_OPC;
                ST_OPC:  if (cnt == CNT_W'(1)) nxt = ST_ADDR;
                ST_ADDR: if (addr_last) begin
                    if (op_sr == OP_READ)                           nxt = ST_RD;
                    else if (op_sr == OP_WRITE)                     nxt = ST_DATA;
                    else if (op_sr == OP_EXT && ext_code == XC_FILL) nxt = ST_DATA;
                    else                                            nxt = ST_HOLD;
                end
                ST_DATA: if (data_last) nxt = ST_HOLD;
                ST_RD, ST_HOLD: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // shift registers, write enable, pending program operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            op_sr     <= '0;
            addr_sr   <= '0;
            data_sr   <= '0;
            rd_sr     <= '0;
            wen       <= 1'b0;
            pend      <= PG_NONE;
            stat_mode <= 1'b0;
        end else if (!cs) begin
            cnt  <= '0;
            pend <= PG_NONE;
            if (pend != PG_NONE) stat_mode <= 1'b1;
        end else if (rise) begin
            cnt <= (nxt != state) ? '0 : cnt + 1'b1;
            unique case (state)
                ST_IDLE: if (din && !busy) stat_mode <= 1'b0;
                ST_OPC:  op_sr <= {op_sr[0], din};
                ST_ADDR: begin
                    addr_sr <= addr_full;
                    if (addr_last) begin
                        if (op_sr == OP_READ)         rd_sr <= {1'b0, rd_word};
                        if (op_sr == OP_ERASE && wen) pend  <= PG_ERASE;
                        if (op_sr == OP_EXT) begin
                            case (ext_code)
                                XC_UNLOCK: wen <= 1'b1;
                                XC_LOCK:   wen <= 1'b0;
                                XC_CLEAR:  if (wen) pend <= PG_ERAL;
                                default:   ;
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    data_sr <= {data_sr[WORD_W-2:0], din};
                    if (data_last && wen)
                        pend <= (op_sr == OP_WRITE) ? PG_WRITE : PG_WRAL;
                end
                ST_RD:   rd_sr <= {rd_sr[WORD_W-1:0], 1'b0};
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout = 1'b0;
        unique case (state)
            ST_IDLE: dout = cs && stat_mode && !busy;
            ST_RD:   dout = rd_sr[WORD_W];
            default: dout = 1'b0;
        endcase
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == ST_IDLE)); // R10
    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wen); // R9
    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit); // R11
    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RD) |-> !dout); // R3
endmodule

// File: tb/eep_serial_bench.sv
module eep_serial_bench;
    localparam int BUSY_T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_a = 1'b0, cs_b = 1'b0, sck = 1'b0, din = 1'b0;
    logic dout_a, dout_b, dout_now;
    logic sel = 1'b0;
    int   checks = 0, errors = 0;

    logic [15:0] mdl [64];
    logic        mwen = 1'b0;

    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    eep_serial #(.ADDR_W(6), .WORD_W(16), .BUSY_CYCLES(BUSY_T)) u_eep_serial (
        .clk(clk), .rst_n(rst_n), .cs(cs_a), .sck(sck), .din(din), .dout(dout_a));
    eep_serial #(.ADDR_W(8), .WORD_W(16), .BUSY_CYCLES(BUSY_T)) u_eep_serial_wide (
        .clk(clk), .rst_n(rst_n), .cs(cs_b), .sck(sck), .din(din), .dout(dout_b));

    assign dout_now = sel ? dout_b : dout_a;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cs(input logic v);
        if (sel) cs_b = v; else cs_a = v;
    endtask

    task automatic sclk(input logic b, output logic o);
        @(negedge clk); din = b; sck = 1'b1;
        @(negedge clk); o = dout_now;
        @(negedge clk); sck = 1'b0;
        @(negedge clk);
    endtask

    function automatic int aw();
        return sel ? 8 : 6;
    endfunction

    task automatic head(input logic [1:0] op, input int addr, output logic o);
        logic d;
        repeat (BUSY_T + 6) @(negedge clk);
        set_cs(1'b1);
        @(negedge clk);
        sclk(1'b1, d);
        sclk(op[1], d);
        sclk(op[0], d);
        o = 1'b0;
        for (int i = aw() - 1; i >= 0; i--) sclk(addr[i], o);
    endtask

    task automatic end_cmd();
        @(negedge clk); set_cs(1'b0); din = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        logic d;
        for (int i = 15; i >= 0; i--) sclk(w[i], d);
    endtask

    task automatic do_write(input int addr, input logic [15:0] w);
        logic d;
        head(2'b01, addr, d);
        send_word(w);
        end_cmd();
        if (!sel && mwen) mdl[addr] = w;
    endtask

    task automatic do_erase(input int addr);
        logic d;
        head(2'b11, addr, d);
        end_cmd();
        if (!sel && mwen) mdl[addr] = 16'hFFFF;
    endtask

    task automatic do_ext(input logic [1:0] code, input int fill, input logic [15:0] w);
        logic d;
        int   a;
        a = (int'(code) << (aw() - 2)) | (fill & ((1 << (aw() - 2)) - 1));
        head(2'b00, a, d);
        if (code == 2'b01) send_word(w);
        end_cmd();
        if (!sel) begin
            if (code == 2'b11) mwen = 1'b1;
            if (code == 2'b00) mwen = 1'b0;
            if (code == 2'b01 && mwen) foreach (mdl[i]) mdl[i] = w;
            if (code == 2'b10 && mwen) foreach (mdl[i]) mdl[i] = 16'hFFFF;
        end
    endtask

    task automatic do_read(input int addr, input logic [15:0] exp, input string tag);
        logic        o;
        logic [15:0] got;
        head(2'b10, addr, o);
        check({tag, " R3 dummy zero"}, {15'd0, o}, 16'd0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 15; i >= 0; i--) begin
            sclk(1'b0, o);
            got[i] = o;
        end
        act_q.push_back(got);
        end_cmd();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic d;
        foreach (mdl[i]) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dout after reset", {15'd0, dout_a}, 16'd0);
        do_read(5, 16'hFFFF, "R1 erased after reset");

        // R9: locked write and no busy status
        do_write(3, 16'hA5A5);
        set_cs(1'b1); repeat (3) @(negedge clk);
        check("R9 no busy when locked", {15'd0, dout_a}, 16'd0);
        set_cs(1'b0);
        do_read(3, mdl[3], "R9 locked write ignored");

        // R2 + R6: leading zeros, unlock with don't-care low bits
        repeat (BUSY_T + 6) @(negedge clk);
        set_cs(1'b1); @(negedge clk);
        sclk(1'b0, d); sclk(1'b0, d); sclk(1'b0, d);
        sclk(1'b1, d); sclk(1'b0, d); sclk(1'b0, d);
        for (int i = 5; i >= 0; i--) sclk(i == 5 || i == 4 || i == 2 || i == 0, d);
        end_cmd();
        mwen = 1'b1;

        // R4 + R11: write and busy status
        do_write(3, 16'hA5A5);
        set_cs(1'b1); repeat (2) @(negedge clk);
        check("R11 dout low while busy", {15'd0, dout_a}, 16'd0);
        repeat (BUSY_T + 4) @(negedge clk);
        check("R11 dout high when ready", {15'd0, dout_a}, 16'd1);
        set_cs(1'b0);
        do_read(3, mdl[3], "R4 write then read R2 R6");
        do_read(4, mdl[4], "R4 neighbour untouched");
        do_write(63, 16'h1234);
        do_write(0, 16'h8001);
        do_read(63, mdl[63], "R4 top address");
        do_read(0, mdl[0], "R4 bottom address");

        // R5
        do_erase(3);
        do_read(3, mdl[3], "R5 erase word");
        do_read(63, mdl[63], "R5 other word kept");

        // R10: abort mid-data
        repeat (BUSY_T + 6) @(negedge clk);
        head(2'b01, 63, d);
        for (int i = 0; i < 8; i++) sclk(1'b1, d);
        end_cmd();
        do_read(63, mdl[63], "R10 aborted write");

        // R8, R7
        do_ext(2'b01, 5, 16'h5A3C);
        do_read(0, mdl[0], "R8 write all low");
        do_read(40, mdl[40], "R8 write all mid");
        do_read(63, mdl[63], "R8 write all top");
        do_ext(2'b10, 9, 16'h0);
        do_read(0, mdl[0], "R7 erase all low");
        do_read(63, mdl[63], "R7 erase all top");

        // R9 + R6: lock again
        do_write(10, 16'h0102);
        do_ext(2'b00, 10, 16'h0);
        do_write(10, 16'h7777);
        do_erase(10);
        do_ext(2'b01, 0, 16'h4444);
        do_read(10, 16'h0102, "R9 R6 locked after disable");

        // R12: wide variant
        sel = 1'b1;
        do_ext(2'b11, 0, 16'h0);
        do_write(200, 16'hBEEF);
        do_read(200, 16'hBEEF, "R12 wide address 200");
        do_read(72, 16'hFFFF, "R12 address 72 distinct");
        do_read(8, 16'hFFFF, "R12 address 8 distinct");

        repeat (10) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule